// File: doc/BRIEF.md
# Channel Enable Delay Sequencer

This block turns a single channel enable input into three timed control outputs for one radio channel: the start of analog power-up, the front-end (antenna switch or low-noise amplifier) switch, and the digital datapath enable. Each output switches a programmable number of system clock cycles after the enable rises or falls. A single elapsed-cycle counter, restarted at every accepted edge, is compared against the programmed delays.

The block also checks its configuration. It flags delay orderings that are illegal for the channel direction. It lowers a requested power-saving level to the highest level that the analog-on delay can support. After a falling edge it refuses any new rising edge until the channel has fully wound down, including the extra power-down time of the active power-saving level. Configuration is written through a small register bank that only accepts writes while the channel is idle.

The sequencer has five named states. IDLE waits for a rising edge. RISE counts toward the analog-on and front-end-on delays. ON holds everything active until the enable falls. FALL counts the hold and front-end-off delays. GAP waits out the power-down margin. The transitions are:
- IDLE to RISE on a rising edge.
- RISE to ON when every rise delay has elapsed.
- RISE or ON to FALL on a falling edge.
- FALL to GAP when all outputs are off.
- FALL or GAP to IDLE when the margin has elapsed.
- FALL or GAP to RISE on a rising edge that arrives exactly at or after the end of the margin.

Top module: `chan_enable_seq`

## Requirements
- R1: After reset, analog_on, fe_on, dp_on, busy, cfg_err, mode_fallback, gap_viol and wr_rej are 0, and mode_eff is 0.
- R2: Suppose the enable is first sampled high at clock edge E. Then analog_on is 1 from the cycle after edge E+A onward, where A is the analog-on delay held in register address 0. Before that it is 0.
- R3: While control bit 1 (front-end use) is 1, fe_on rises in the cycle after edge E+N, where N is the delay at address 1. While that bit is 0, fe_on never asserts.
- R4: dp_on is 1 in the cycle after a rising edge is accepted. Suppose the enable is first sampled low at edge F. Then analog_on and dp_on are 0 from the cycle after edge F+H onward, where H is the hold delay at address 3.
- R5: fe_on (if it was on) drops in the cycle after edge F+K, where K is the front-end-off delay at address 2.
- R6: cfg_err is 1 when front-end use is on and the address 1 delay is less than the address 0 delay.
- R7: Control bit 0 selects the direction. When it is 1 (transmit), cfg_err is 1 if H > K. When it is 0 (receive), cfg_err is 1 if K > H.
- R8: The requested level is in control bits 3:2. The effective level mode_eff is recomputed on every accepted write to address 0 or 4. A level of 2 or more is reduced to 1 when the address 0 delay is below PU2. A level of 1 or more is reduced to 0 when that delay is below PU1. mode_fallback is 1 whenever mode_eff differs from the request.
- R9: Let G = max(H, K if the front end was on) + P, where P is 0, PD1 or PD2 for effective level 0, 1 or at least 2. A rising edge sampled at edge F+j is accepted only if j ≥ G+1. An earlier rising edge is ignored and sets the sticky gap_viol.
- R10: A write to address 5 clears gap_viol when data bit 0 is 1 and clears wr_rej when data bit 1 is 1. This write is accepted at any time.
- R11: A write to addresses 0 to 4 while busy or while the enable is high is discarded and sets the sticky wr_rej. The programmed delays stay unchanged.
- R12: busy is 1 from the cycle after an accepted rising edge until the cycle after edge F+G+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 analog-on, 1 front-end-on, 2 front-end-off, 3 hold, 4 control, 5 clear) |
| cfg_wdata | input | DLY_W | Register write data |
| analog_on | output | 1 | Analog power-up start |
| fe_on | output | 1 | Front-end switch on |
| dp_on | output | 1 | Digital datapath enable |
| busy | output | 1 | Sequencer not idle |
| cfg_err | output | 1 | Delay ordering illegal |
| mode_eff | output | 2 | Effective power-saving level |
| mode_fallback | output | 1 | Requested level was reduced |
| gap_viol | output | 1 | Sticky: early rising edge ignored |
| wr_rej | output | 1 | Sticky: write discarded while active |

## Verification
The hardest situation to reach from the ports is a rising edge that lands exactly at the end of the post-fall margin. An edge one cycle earlier must be refused, and an edge at the boundary must be accepted. The margin combines the hold delay, the front-end-off delay and the power-down time of a level that was itself lowered at write time. The bench therefore first programs a request that falls back to level 1 and confirms the fallback. It then drops the enable and re-raises it at a counted offset in the FALL or GAP window, once at G and once at G+1. The bench reads the verdict from gap_viol and from dp_on in the following cycle.

// File: rtl/ced_pkg.sv
package ced_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RISE,
        S_ON,
        S_FALL,
        S_GAP
    } seq_state_t;

    localparam logic [2:0] A_RISE_AN  = 3'd0;
    localparam logic [2:0] A_RISE_ON  = 3'd1;
    localparam logic [2:0] A_FALL_OFF = 3'd2;
    localparam logic [2:0] A_HOLD     = 3'd3;
    localparam logic [2:0] A_CTRL     = 3'd4;
    localparam logic [2:0] A_CLEAR    = 3'd5;

    localparam int CTL_TX   = 0;
    localparam int CTL_FE   = 1;
    localparam int CTL_MODE = 2;

endpackage

// File: rtl/ced_mode_judge.sv
module ced_mode_judge #(
    parameter int DLY_W = 24,
    parameter int PU1   = 4,
    parameter int PU2   = 8
) (
    input  logic [1:0]       req,
    input  logic [DLY_W-1:0] rise_an,
    output logic [1:0]       eff
);
    localparam logic [DLY_W-1:0] PU1_V = DLY_W'(PU1);
    localparam logic [DLY_W-1:0] PU2_V = DLY_W'(PU2);

    always_comb begin
        eff = req;
        if (eff >= 2'd2 && rise_an < PU2_V) begin
            eff = 2'd1;
        end
        if (eff >= 2'd1 && rise_an < PU1_V) begin
            eff = 2'd0;
        end
    end
endmodule

// File: rtl/ced_cfg_bank.sv
module ced_cfg_bank
    import ced_pkg::*;
#(
    parameter int DLY_W = 24,
    parameter int PU1   = 4,
    parameter int PU2   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [DLY_W-1:0] cfg_wdata,
    input  logic             idle,
    input  logic             gap_hit,
    output logic [DLY_W-1:0] rise_an,
    output logic [DLY_W-1:0] rise_on,
    output logic [DLY_W-1:0] fall_off,
    output logic [DLY_W-1:0] hold,
    output logic             tx,
    output logic             fe_en,
    output logic [1:0]       mode_eff,
    output logic             mode_fallback,
    output logic             cfg_err,
    output logic             gap_viol,
    output logic             wr_rej
);
    logic       is_cfg_addr;
    logic       wr_ok;
    logic       wr_bad;
    logic       clr_wr;
    logic [1:0] mode_req;
    logic [1:0] j_req;
    logic [DLY_W-1:0] j_an;
    logic [1:0] j_eff;

    assign is_cfg_addr = (cfg_addr <= A_CTRL);
    assign wr_ok       = cfg_we && is_cfg_addr && idle;
    assign wr_bad      = cfg_we && is_cfg_addr && !idle;
    assign clr_wr      = cfg_we && (cfg_addr == A_CLEAR);

    // Legality is judged against the values that will be stored after this write.
    assign j_req = (cfg_we && cfg_addr == A_CTRL) ? cfg_wdata[CTL_MODE +: 2] : mode_req;
    assign j_an  = (cfg_we && cfg_addr == A_RISE_AN) ? cfg_wdata : rise_an;

    ced_mode_judge #(.DLY_W(DLY_W), .PU1(PU1), .PU2(PU2)) u_judge (
        .req     (j_req),
        .rise_an (j_an),
        .eff     (j_eff)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_an  <= '0;
            rise_on  <= '0;
            fall_off <= '0;
            hold     <= '0;
            tx       <= 1'b0;
            fe_en    <= 1'b0;
            mode_req <= 2'd0;
            mode_eff <= 2'd0;
        end else if (wr_ok) begin
            unique case (cfg_addr)
                A_RISE_AN: begin
                    rise_an  <= cfg_wdata;
                    mode_eff <= j_eff;
                end
                A_RISE_ON:  rise_on  <= cfg_wdata;
                A_FALL_OFF: fall_off <= cfg_wdata;
                A_HOLD:     hold     <= cfg_wdata;
                A_CTRL: begin
                    tx       <= cfg_wdata[CTL_TX];
                    fe_en    <= cfg_wdata[CTL_FE];
                    mode_req <= cfg_wdata[CTL_MODE +: 2];
                    mode_eff <= j_eff;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_viol <= 1'b0;
            wr_rej   <= 1'b0;
        end else begin
            if (gap_hit) begin
                gap_viol <= 1'b1;
            end else if (clr_wr && cfg_wdata[0]) begin
                gap_viol <= 1'b0;
            end
            if (wr_bad) begin
                wr_rej <= 1'b1;
            end else if (clr_wr && cfg_wdata[1]) begin
                wr_rej <= 1'b0;
            end
        end
    end

    assign mode_fallback = (mode_eff != mode_req);

    always_comb begin
        cfg_err = 1'b0;
        if (fe_en && rise_on < rise_an) begin
            cfg_err = 1'b1;
        end
        if (tx && hold > fall_off) begin
            cfg_err = 1'b1;
        end
        if (!tx && fall_off > hold) begin
            cfg_err = 1'b1;
        end
    end
endmodule

// File: rtl/ced_seq_fsm.sv
module ced_seq_fsm
    import ced_pkg::*;
#(
    parameter int DLY_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic [DLY_W-1:0] rise_an,
    input  logic [DLY_W-1:0] rise_on,
    input  logic [DLY_W-1:0] fall_off,
    input  logic [DLY_W-1:0] hold,
    input  logic             fe_en,
    input  logic [DLY_W-1:0] pd_extra,
    output logic             analog_on,
    output logic             fe_on,
    output logic             dp_on,
    output logic             busy,
    output logic             idle,
    output logic             gap_hit
);
    localparam int CW = DLY_W + 2;
    localparam logic [CW-1:0] CNT_MAX = '1;

    seq_state_t state, state_nx;
    logic [CW-1:0] cnt, cnt_nx, cnt_inc;
    logic          en_d;
    logic          an_seen, an_seen_nx;
    logic          fe_seen, fe_seen_nx;
    logic          rise_edge, fall_edge;
    logic [CW-1:0] ra_x, ro_x, fo_x, ho_x, pd_x;
    logic [CW-1:0] fe_part, f_len, g_len;
    logic          rise_done;

    assign ra_x = {2'b00, rise_an};
    assign ro_x = {2'b00, rise_on};
    assign fo_x = {2'b00, fall_off};
    assign ho_x = {2'b00, hold};
    assign pd_x = {2'b00, pd_extra};

    assign rise_edge = chan_en && !en_d;
    assign fall_edge = !chan_en && en_d;
    assign cnt_inc   = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

    assign fe_part   = fe_seen ? fo_x : '0;
    assign f_len     = (ho_x > fe_part) ? ho_x : fe_part;
    assign g_len     = f_len + pd_x;
    assign rise_done = (cnt >= ra_x) && (!fe_en || cnt >= ro_x);

    // Next-state logic
    always_comb begin
        state_nx   = state;
        cnt_nx     = cnt_inc;
        an_seen_nx = an_seen;
        fe_seen_nx = fe_seen;
        gap_hit    = 1'b0;
        unique case (state)
            S_IDLE: begin
                cnt_nx = '0;
                if (rise_edge) begin
                    state_nx = S_RISE;
                end
            end
            S_RISE: begin
                if (fall_edge) begin
                    state_nx   = S_FALL;
                    cnt_nx     = '0;
                    an_seen_nx = (cnt >= ra_x);
                    fe_seen_nx = fe_en && (cnt >= ro_x);
                end else if (rise_done) begin
                    state_nx = S_ON;
                end
            end
            S_ON: begin
                cnt_nx = cnt;
                if (fall_edge) begin
                    state_nx   = S_FALL;
                    cnt_nx     = '0;
                    an_seen_nx = 1'b1;
                    fe_seen_nx = fe_en;
                end
            end
            S_FALL, S_GAP: begin
                if (rise_edge) begin
                    if (cnt >= g_len) begin
                        state_nx = S_RISE;
                        cnt_nx   = '0;
                    end else begin
                        gap_hit = 1'b1;
                    end
                end else if (cnt >= g_len) begin
                    state_nx = S_IDLE;
                end else if (state == S_FALL && cnt >= f_len) begin
                    state_nx = S_GAP;
                end
            end
            default: begin
                state_nx = S_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            en_d    <= 1'b0;
            an_seen <= 1'b0;
            fe_seen <= 1'b0;
        end else begin
            state   <= state_nx;
            cnt     <= cnt_nx;
            en_d    <= chan_en;
            an_seen <= an_seen_nx;
            fe_seen <= fe_seen_nx;
        end
    end

    // Outputs
    always_comb begin
        analog_on = 1'b0;
        fe_on     = 1'b0;
        dp_on     = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_RISE: begin
                analog_on = (cnt >= ra_x);
                fe_on     = fe_en && (cnt >= ro_x);
                dp_on     = 1'b1;
            end
            S_ON: begin
                analog_on = 1'b1;
                fe_on     = fe_en;
                dp_on     = 1'b1;
            end
            S_FALL: begin
                analog_on = an_seen && (cnt < ho_x);
                fe_on     = fe_seen && (cnt < fo_x);
                dp_on     = (cnt < ho_x);
            end
            S_GAP: ;
            default: ;
        endcase
    end

    assign busy = (state != S_IDLE);
    assign idle = (state == S_IDLE) && !chan_en;
endmodule

// File: rtl/chan_enable_seq.sv
module chan_enable_seq #(
    parameter int DLY_W = 24,
    parameter int PU1   = 4,
    parameter int PU2   = 8,
    parameter int PD1   = 3,
    parameter int PD2   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [DLY_W-1:0] cfg_wdata,
    output logic             analog_on,
    output logic             fe_on,
    output logic             dp_on,
    output logic             busy,
    output logic             cfg_err,
    output logic [1:0]       mode_eff,
    output logic             mode_fallback,
    output logic             gap_viol,
    output logic             wr_rej
);
    logic [DLY_W-1:0] rise_an, rise_on, fall_off, hold, pd_extra;
    logic             tx, fe_en, idle, gap_hit;

    ced_cfg_bank #(.DLY_W(DLY_W), .PU1(PU1), .PU2(PU2)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .idle          (idle),
        .gap_hit       (gap_hit),
        .rise_an       (rise_an),
        .rise_on       (rise_on),
        .fall_off      (fall_off),
        .hold          (hold),
        .tx            (tx),
        .fe_en         (fe_en),
        .mode_eff      (mode_eff),
        .mode_fallback (mode_fallback),
        .cfg_err       (cfg_err),
        .gap_viol      (gap_viol),
        .wr_rej        (wr_rej)
    );

    always_comb begin
        unique case (mode_eff)
            2'd0:    pd_extra = '0;
            2'd1:    pd_extra = DLY_W'(PD1);
            default: pd_extra = DLY_W'(PD2);
        endcase
    end

    ced_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .rise_an   (rise_an),
        .rise_on   (rise_on),
        .fall_off  (fall_off),
        .hold      (hold),
        .fe_en     (fe_en),
        .pd_extra  (pd_extra),
        .analog_on (analog_on),
        .fe_on     (fe_on),
        .dp_on     (dp_on),
        .busy      (busy),
        .idle      (idle),
        .gap_hit   (gap_hit)
    );
endmodule

// File: rtl/chan_enable_seq_chk.sv
module chan_enable_seq_chk #(
    parameter int DLY_W = 24,
    parameter int PU1   = 4,
    parameter int PU2   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chan_en,
    input logic             cfg_we,
    input logic [2:0]       cfg_addr,
    input logic [DLY_W-1:0] cfg_wdata,
    input logic             analog_on,
    input logic             fe_on,
    input logic             dp_on,
    input logic             busy,
    input logic             gap_viol,
    input logic             wr_rej,
    input logic             fe_en,
    input logic [1:0]       mode_eff,
    input logic [DLY_W-1:0] rise_an
);
    // R3
    fe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fe_on |-> fe_en);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!analog_on && !fe_on && !dp_on));

    // R2
    analog_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(analog_on) |-> $past(chan_en));

    // R8
    mode1_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff != 2'd0) |-> (rise_an >= DLY_W'(PU1)));

    // R8
    mode2_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff >= 2'd2) |-> (rise_an >= DLY_W'(PU2)));

    // R9
    gap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_viol && !(cfg_we && cfg_addr == 3'd5 && cfg_wdata[0])) |=> gap_viol);

    // R11
    wr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr <= 3'd4 && (busy || chan_en)) |=> wr_rej);
endmodule

bind chan_enable_seq chan_enable_seq_chk #(.DLY_W(DLY_W), .PU1(PU1), .PU2(PU2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .analog_on (analog_on),
    .fe_on     (fe_on),
    .dp_on     (dp_on),
    .busy      (busy),
    .gap_viol  (gap_viol),
    .wr_rej    (wr_rej),
    .fe_en     (fe_en),
    .mode_eff  (mode_eff),
    .rise_an   (rise_an)
);

// File: tb/chan_enable_seq_test.sv
`timescale 1ns/1ps
module chan_enable_seq_test;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chan_en = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          analog_on, fe_on, dp_on, busy, cfg_err, mode_fallback, gap_viol, wr_rej;
    logic [1:0]    mode_eff;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    chan_enable_seq uut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .analog_on(analog_on), .fe_on(fe_on), .dp_on(dp_on), .busy(busy),
        .cfg_err(cfg_err), .mode_eff(mode_eff), .mode_fallback(mode_fallback),
        .gap_viol(gap_viol), .wr_rej(wr_rej)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = DW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 analog_on", analog_on, 0);
        chk("R1 fe_on", fe_on, 0);
        chk("R1 dp_on", dp_on, 0);
        chk("R1 busy", busy, 0);
        chk("R1 flags", {cfg_err, mode_fallback, gap_viol, wr_rej}, 0);
        chk("R1 mode_eff", mode_eff, 0);
    endtask

    task automatic t_rise_fall;
        wr(3'd0, 3); wr(3'd1, 5); wr(3'd2, 4); wr(3'd3, 2);
        wr(3'd4, 'b0011);
        chk("R7 tx valid cfg_err", cfg_err, 0);
        @(negedge clk); chan_en = 1'b1;
        for (int k = 0; k <= 6; k++) begin
            @(negedge clk);
            chk($sformatf("R2 analog k=%0d", k), analog_on, (k >= 3));
            chk($sformatf("R3 fe k=%0d", k), fe_on, (k >= 5));
            chk($sformatf("R4 dp rise k=%0d", k), dp_on, 1);
            if (k == 0) chk("R12 busy on rise", busy, 1);
        end
        chan_en = 1'b0;
        for (int k = 0; k <= 5; k++) begin
            @(negedge clk);
            chk($sformatf("R4 analog fall k=%0d", k), analog_on, (k < 2));
            chk($sformatf("R4 dp fall k=%0d", k), dp_on, (k < 2));
            chk($sformatf("R5 fe fall k=%0d", k), fe_on, (k < 4));
            if (k == 4) chk("R12 busy k=4", busy, 1);
            if (k == 5) chk("R12 busy k=5", busy, 0);
        end
    endtask

    task automatic t_nofe;
        wr(3'd4, 'b0001);
        @(negedge clk); chan_en = 1'b1;
        for (int k = 0; k <= 7; k++) begin
            @(negedge clk);
            chk($sformatf("R3 fe disabled k=%0d", k), fe_on, 0);
        end
        chan_en = 1'b0;
        settle(12);
    endtask

    task automatic t_cfg;
        wr(3'd4, 'b0010);
        wr(3'd0, 5); wr(3'd1, 3);
        chk("R6 rise_on<rise_an", cfg_err, 1);
        wr(3'd1, 6);
        wr(3'd2, 4); wr(3'd3, 2);
        chk("R7 rx fall_off>hold", cfg_err, 1);
        wr(3'd3, 4);
        chk("R7 rx valid", cfg_err, 0);
        wr(3'd4, 'b0011); wr(3'd3, 5);
        chk("R7 tx hold>fall_off", cfg_err, 1);
    endtask

    task automatic t_mode;
        wr(3'd0, 3); wr(3'd4, 'b1001);
        chk("R8 low delay eff", mode_eff, 0);
        chk("R8 low delay fallback", mode_fallback, 1);
        wr(3'd0, 8);
        chk("R8 recheck on delay write", mode_eff, 2);
        chk("R8 no fallback", mode_fallback, 0);
        wr(3'd4, 'b1101);
        chk("R8 level 3 kept", mode_eff, 3);
        wr(3'd0, 5);
        chk("R8 drop to 1", mode_eff, 1);
    endtask

    task automatic t_gap;
        // level 1 effective: G = max(2,4) + 3 = 7
        wr(3'd0, 5); wr(3'd1, 5); wr(3'd2, 4); wr(3'd3, 2);
        wr(3'd4, 'b1011);
        chk("R8 fallback to 1", mode_eff, 1);
        chk("R8 fallback flag", mode_fallback, 1);
        @(negedge clk); chan_en = 1'b1;
        settle(8);
        chan_en = 1'b0;
        for (int k = 0; k <= 6; k++) begin
            @(negedge clk);
            if (k == 6) chan_en = 1'b1;
        end
        @(negedge clk);
        chk("R9 early rise flagged", gap_viol, 1);
        chk("R9 early rise no dp", dp_on, 0);
        settle(10);
        chk("R9 ignored busy", busy, 0);
        chk("R9 ignored analog", analog_on, 0);
        chan_en = 1'b0;
        wr(3'd5, 1);
        chk("R10 clear gap_viol", gap_viol, 0);
        @(negedge clk); chan_en = 1'b1;
        settle(8);
        chan_en = 1'b0;
        for (int k = 0; k <= 7; k++) begin
            @(negedge clk);
            if (k == 7) chan_en = 1'b1;
        end
        @(negedge clk);
        chk("R9 boundary rise accepted", dp_on, 1);
        chk("R9 boundary no flag", gap_viol, 0);
    endtask

    task automatic t_wrrej;
        // channel still on from t_gap (analog-on delay 5)
        wr(3'd0, 1);
        chk("R11 wr_rej set", wr_rej, 1);
        chan_en = 1'b0;
        settle(14);
        chk("R11 sticky after idle", wr_rej, 1);
        wr(3'd5, 2);
        chk("R10 clear wr_rej", wr_rej, 0);
        @(negedge clk); chan_en = 1'b1;
        for (int k = 0; k <= 5; k++) begin
            @(negedge clk);
            if (k == 4) chk("R11 delay kept k=4", analog_on, 0);
            if (k == 5) chk("R11 delay kept k=5", analog_on, 1);
        end
        chan_en = 1'b0;
        settle(14);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        settle(3);
        t_reset;
        @(negedge clk); rst_n = 1'b1;
        settle(2);
        t_reset;
        t_rise_fall;
        settle(4);
        t_nofe;
        t_cfg;
        t_mode;
        t_gap;
        t_wrrej;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule